// File: doc/BRIEF.md
# Expansion RAM DMA Controller

This block is a byte-wide DMA engine that sits between a host memory bus and a 256 KiB expansion RAM. Software programs a host address, an expansion address, a transfer length and an address-hold control through a small byte-addressed register file. It then writes a command byte. The engine moves one byte per step in one of four operations: copy host to expansion, copy expansion to host, exchange the two bytes, or compare them. It reports the outcome through sticky flags in a status register.

Both memories sit outside the block and respond one cycle after an address is presented. Each byte takes a FETCH cycle, which presents both addresses, and a STORE cycle, which writes or compares the returned data and advances the addresses. A final FINISH cycle updates the status flags and the address registers. The state machine has four states. IDLE goes to FETCH on a start command. FETCH always goes to STORE. STORE goes back to FETCH while bytes remain. STORE goes to FINISH on the last byte, or on the first mismatch in compare mode. FINISH always returns to IDLE.

When a transfer ends, the address registers either return to the values software programmed (autoload) or show the final addresses.

Top module: `xram_dma`

## Requirements
- R1: After reset every register reads 0x00 and `busy` is low.
- R2: A write to register 1 starts a transfer only when bit 7 of the byte is 1 and bit 4 is 0. Any other command value is stored and readable, but touches neither memory and leaves `busy` low.
- R3: Command bits [1:0] = 0 copies each host byte to the expansion RAM.
- R4: Command bits [1:0] = 1 copies each expansion byte to the host.
- R5: Command bits [1:0] = 2 exchanges the two bytes at each address pair. The host byte read before the step ends up in the expansion RAM, and the expansion byte ends up at the host address.
- R6: Command bits [1:0] = 3 compares without writing. The first unequal pair sets status bit 5 and ends the transfer after that pair's addresses have advanced.
- R7: Every transfer sets status bit 6 when it ends, including one ended early. Reading register 0 returns the flags and then clears bits 5 and 6.
- R8: The length is register 8 (high byte) and register 7 (low byte), and a value of 0 moves 65536 bytes. The length registers keep their programmed value after the transfer.
- R9: The expansion address is 18 bits wide: register 6 bits [1:0], register 5 and register 4 (low byte). It wraps from 0x3FFFF to 0. The host address is register 3 (high) and register 2 (low), and it wraps at 16 bits.
- R10: Register 10 bit 7 holds the host address fixed, and bit 6 holds the expansion address fixed, for the whole transfer.
- R11: With command bit 5 set, registers 2 to 8 return to their programmed values at the end of a transfer. With bit 5 clear, registers 2 to 6 receive the final host address and the final expansion address.
- R12: `busy` is high from the cycle after a start until the transfer ends. Memory writes happen only while `busy` is high. Register writes, including a new command, are ignored while `busy` is high.
- R13: A transfer that handles N bytes keeps `busy` high for exactly 2N+1 cycles, and each memory write uses the address presented in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (clears status flags when it reads register 0) |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, combinational from `cpu_addr` |
| busy | output | 1 | Transfer in progress |
| h_addr | output | 16 | Host memory address |
| h_we | output | 1 | Host memory write enable |
| h_wdata | output | 8 | Host memory write data |
| h_rdata | input | 8 | Host memory read data, one cycle after the address |
| x_addr | output | 18 | Expansion RAM address |
| x_we | output | 1 | Expansion RAM write enable |
| x_wdata | output | 8 | Expansion RAM write data |
| x_rdata | input | 8 | Expansion RAM read data, one cycle after the address |

## Verification
The bench targets the following corner cases:

- A compare that stops at its sixth byte. A design that kept going, or that did not advance the addresses past the bad pair, would read back wrong final addresses.
- An expansion start address of 0x3FFFC. A design without the 18-bit wrap would leak into register 6 bit 2.
- A length of 0. A design that treated it as 0 would end at once instead of running 65536 steps.
- Swap in a single step. A design that read and wrote in the wrong order would copy one byte over the other instead of exchanging them.
- Register and command writes made mid-transfer. A design that accepted them would show changed registers or restart the transfer.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_FINISH
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_TO_XRAM = 2'd0,
        OP_TO_HOST = 2'd1,
        OP_SWAP    = 2'd2,
        OP_VERIFY  = 2'd3
    } xfer_op_t;

    localparam int BYTE_W    = 8;
    localparam int RA_STATUS = 0;
    localparam int RA_CMD    = 1;
    localparam int RA_CTRL   = 10;
    localparam int WIN_LO    = 2;   // first address/length register
    localparam int WIN_HI    = 8;   // last address/length register

    localparam int CMD_GO_BIT   = 7;
    localparam int CMD_HOLD_BIT = 4;
    localparam int CMD_AUTO_BIT = 5;
    localparam int CTL_HFIX_BIT = 7;
    localparam int CTL_XFIX_BIT = 6;

endpackage

// File: rtl/xdma_engine.sv
module xdma_engine
    import xdma_pkg::*;
#(
    parameter int HAW = 16,
    parameter int XAW = 18,
    parameter int LW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_op_t          start_op,
    input  logic [HAW-1:0]    cfg_haddr,
    input  logic [XAW-1:0]    cfg_xaddr,
    input  logic [LW-1:0]     cfg_len,
    input  logic              cfg_hfix,
    input  logic              cfg_xfix,
    input  logic [BYTE_W-1:0] h_rdata,
    input  logic [BYTE_W-1:0] x_rdata,
    output logic              busy,
    output logic              fin,
    output logic              fin_miss,
    output logic [HAW-1:0]    cur_haddr,
    output logic [XAW-1:0]    cur_xaddr,
    output logic              h_we,
    output logic [BYTE_W-1:0] h_wdata,
    output logic              x_we,
    output logic [BYTE_W-1:0] x_wdata
);
    localparam int CW = LW + 1;

    eng_state_t     state, nxt;
    xfer_op_t       op_q;
    logic [HAW-1:0] haddr_q;
    logic [XAW-1:0] xaddr_q;
    logic [CW-1:0]  remain_q;
    logic           hfix_q, xfix_q, miss_q;
    logic           mismatch, last_step;

    assign mismatch  = (op_q == OP_VERIFY) && (h_rdata != x_rdata);
    assign last_step = (remain_q == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_STORE;
            ST_STORE:  nxt = (mismatch || last_step) ? ST_FINISH : ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        h_we    = 1'b0;
        x_we    = 1'b0;
        h_wdata = x_rdata;
        x_wdata = h_rdata;
        if (state == ST_STORE) begin
            unique case (op_q)
                OP_TO_XRAM: x_we = 1'b1;
                OP_TO_HOST: h_we = 1'b1;
                OP_SWAP: begin
                    h_we = 1'b1;
                    x_we = 1'b1;
                end
                OP_VERIFY: ;
                default: ;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign fin       = (state == ST_FINISH);
    assign fin_miss  = miss_q;
    assign cur_haddr = haddr_q;
    assign cur_xaddr = xaddr_q;

    // address counters, step count and mismatch flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_TO_XRAM;
            haddr_q  <= '0;
            xaddr_q  <= '0;
            remain_q <= '0;
            hfix_q   <= 1'b0;
            xfix_q   <= 1'b0;
            miss_q   <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            op_q     <= start_op;
            haddr_q  <= cfg_haddr;
            xaddr_q  <= cfg_xaddr;
            remain_q <= (cfg_len == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, cfg_len};
            hfix_q   <= cfg_hfix;
            xfix_q   <= cfg_xfix;
            miss_q   <= 1'b0;
        end else if (state == ST_STORE) begin
            if (!hfix_q) haddr_q <= haddr_q + 1'b1;
            if (!xfix_q) xaddr_q <= xaddr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            if (mismatch) miss_q <= 1'b1;
        end
    end

endmodule

// File: rtl/xdma_regs.sv
module xdma_regs
    import xdma_pkg::*;
#(
    parameter int HAW = 16,
    parameter int XAW = 18,
    parameter int LW  = 16,
    parameter int RAW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [RAW-1:0]    cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fin_miss,
    input  logic [HAW-1:0]    fin_haddr,
    input  logic [XAW-1:0]    fin_xaddr,
    output logic              start,
    output xfer_op_t          start_op,
    output logic [HAW-1:0]    cfg_haddr,
    output logic [XAW-1:0]    cfg_xaddr,
    output logic [LW-1:0]     cfg_len,
    output logic              cfg_hfix,
    output logic              cfg_xfix
);
    logic [BYTE_W-1:0] wk_q [WIN_LO:WIN_HI];   // visible values
    logic [BYTE_W-1:0] pg_q [WIN_LO:WIN_HI];   // last programmed values
    logic [BYTE_W-1:0] cmd_q, ctrl_q;
    logic              done_q, verr_q;
    logic [15:0]       fin_h16;
    logic [23:0]       fin_x24;

    assign fin_h16 = 16'(fin_haddr);
    assign fin_x24 = 24'(fin_xaddr);

    assign start = cpu_we && !busy && (cpu_addr == RAW'(RA_CMD))
                && cpu_wdata[CMD_GO_BIT] && !cpu_wdata[CMD_HOLD_BIT];
    assign start_op  = xfer_op_t'(cpu_wdata[1:0]);
    assign cfg_haddr = HAW'({wk_q[3], wk_q[2]});
    assign cfg_xaddr = XAW'({wk_q[6], wk_q[5], wk_q[4]});
    assign cfg_len   = LW'({wk_q[8], wk_q[7]});
    assign cfg_hfix  = ctrl_q[CTL_HFIX_BIT];
    assign cfg_xfix  = ctrl_q[CTL_XFIX_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = WIN_LO; i <= WIN_HI; i++) begin
                wk_q[i] <= '0;
                pg_q[i] <= '0;
            end
            cmd_q  <= '0;
            ctrl_q <= '0;
            done_q <= 1'b0;
            verr_q <= 1'b0;
        end else begin
            if (cpu_re && cpu_addr == RAW'(RA_STATUS)) begin
                done_q <= 1'b0;
                verr_q <= 1'b0;
            end
            if (cpu_we && !busy) begin
                if (cpu_addr == RAW'(RA_CMD))  cmd_q  <= cpu_wdata;
                if (cpu_addr == RAW'(RA_CTRL)) ctrl_q <= cpu_wdata;
                for (int i = WIN_LO; i <= WIN_HI; i++) begin
                    if (cpu_addr == RAW'(i)) begin
                        wk_q[i] <= cpu_wdata;
                        pg_q[i] <= cpu_wdata;
                    end
                end
            end
            if (fin) begin
                done_q <= 1'b1;
                if (fin_miss) verr_q <= 1'b1;
                if (cmd_q[CMD_AUTO_BIT]) begin
                    for (int i = WIN_LO; i <= WIN_HI; i++) wk_q[i] <= pg_q[i];
                end else begin
                    wk_q[2] <= fin_h16[7:0];
                    wk_q[3] <= fin_h16[15:8];
                    wk_q[4] <= fin_x24[7:0];
                    wk_q[5] <= fin_x24[15:8];
                    wk_q[6] <= fin_x24[23:16];
                end
            end
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == RAW'(RA_STATUS)) cpu_rdata = {1'b0, done_q, verr_q, 5'b0};
        if (cpu_addr == RAW'(RA_CMD))    cpu_rdata = cmd_q;
        if (cpu_addr == RAW'(RA_CTRL))   cpu_rdata = ctrl_q;
        for (int i = WIN_LO; i <= WIN_HI; i++) begin
            if (cpu_addr == RAW'(i)) cpu_rdata = wk_q[i];
        end
    end

endmodule

// File: rtl/xram_dma.sv
module xram_dma
    import xdma_pkg::*;
#(
    parameter int HAW = 16,
    parameter int XAW = 18,
    parameter int LW  = 16,
    parameter int RAW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [RAW-1:0]    cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              busy,
    output logic [HAW-1:0]    h_addr,
    output logic              h_we,
    output logic [BYTE_W-1:0] h_wdata,
    input  logic [BYTE_W-1:0] h_rdata,
    output logic [XAW-1:0]    x_addr,
    output logic              x_we,
    output logic [BYTE_W-1:0] x_wdata,
    input  logic [BYTE_W-1:0] x_rdata
);
    logic           start, fin, fin_miss, hfix, xfix;
    xfer_op_t       start_op;
    logic [HAW-1:0] cfg_haddr;
    logic [XAW-1:0] cfg_xaddr;
    logic [LW-1:0]  cfg_len;

    xdma_regs #(.HAW(HAW), .XAW(XAW), .LW(LW), .RAW(RAW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_re    (cpu_re),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_miss  (fin_miss),
        .fin_haddr (h_addr),
        .fin_xaddr (x_addr),
        .start     (start),
        .start_op  (start_op),
        .cfg_haddr (cfg_haddr),
        .cfg_xaddr (cfg_xaddr),
        .cfg_len   (cfg_len),
        .cfg_hfix  (hfix),
        .cfg_xfix  (xfix)
    );

    xdma_engine #(.HAW(HAW), .XAW(XAW), .LW(LW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_op  (start_op),
        .cfg_haddr (cfg_haddr),
        .cfg_xaddr (cfg_xaddr),
        .cfg_len   (cfg_len),
        .cfg_hfix  (hfix),
        .cfg_xfix  (xfix),
        .h_rdata   (h_rdata),
        .x_rdata   (x_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_miss  (fin_miss),
        .cur_haddr (h_addr),
        .cur_xaddr (x_addr),
        .h_we      (h_we),
        .h_wdata   (h_wdata),
        .x_we      (x_we),
        .x_wdata   (x_wdata)
    );

endmodule

// File: rtl/xram_dma_chk.sv
module xram_dma_chk #(
    parameter int HAW = 16,
    parameter int XAW = 18,
    parameter int RAW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_we,
    input logic [RAW-1:0] cpu_addr,
    input logic [7:0]     cpu_wdata,
    input logic [7:0]     cpu_rdata,
    input logic           busy,
    input logic [HAW-1:0] h_addr,
    input logic           h_we,
    input logic [XAW-1:0] x_addr,
    input logic           x_we
);
    logic go_cmd, held_cmd;
    assign go_cmd   = cpu_we && !busy && cpu_addr == RAW'(1) && cpu_wdata[7] && !cpu_wdata[4];
    assign held_cmd = cpu_we && !busy && cpu_addr == RAW'(1) && cpu_wdata[4];

    // R12
    mem_write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we || x_we) |-> busy);

    // R12
    start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_cmd |=> busy);

    // R2
    held_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_cmd |=> !busy);

    // R7
    done_flag_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cpu_addr == RAW'(0)) |-> cpu_rdata[6]);

    // R13
    write_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we || x_we) |-> ($stable(h_addr) && $stable(x_addr)));

endmodule

bind xram_dma xram_dma_chk #(.HAW(HAW), .XAW(XAW), .RAW(RAW)) u_chk (.*);

// File: tb/test_xram_dma.sv
module test_xram_dma;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0, cpu_re = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       busy;
    logic [15:0] h_addr;
    logic [17:0] x_addr;
    logic        h_we, x_we;
    logic [7:0]  h_wdata, x_wdata, h_rdata, x_rdata;

    logic [7:0] hm [4096];
    logic [7:0] xm [4096];
    logic [7:0] rh [4096];
    logic [7:0] rx [4096];

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    xram_dma i_xram_dma (.*);

    always @(posedge clk) begin
        if (h_we) hm[h_addr[11:0]] <= h_wdata;
        if (x_we) xm[x_addr[11:0]] <= x_wdata;
        h_rdata <= hm[h_addr[11:0]];
        x_rdata <= xm[x_addr[11:0]];
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = 8'(d);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        cpu_re = 1'b1; cpu_addr = 4'(a);
        #1 d = int'(cpu_rdata);
        @(negedge clk);
        cpu_re = 1'b0;
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, at = -1, a = 0, e = 0;
        for (int i = 0; i < 4096; i++) begin
            if (hm[i] !== rh[i]) begin bad++; if (at < 0) begin at = i; a = hm[i]; e = rh[i]; end end
            if (xm[i] !== rx[i]) begin bad++; if (at < 0) begin at = 4096 + i; a = xm[i]; e = rx[i]; end end
        end
        chk(bad == 0, req, $sformatf("memory byte %0d", at), a, e);
    endtask

    // reference transfer on rh/rx
    task automatic ref_run(input int op, input int h0, input int x0, input int len,
                           input bit hf, input bit xf,
                           output int hend, output int xend, output bit miss, output int steps);
        int h = h0, x = x0;
        int n = (len == 0) ? 65536 : len;
        miss = 1'b0; steps = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] a, b;
            a = rh[h & 12'hFFF];
            b = rx[x & 12'hFFF];
            case (op)
                0: rx[x & 12'hFFF] = a;
                1: rh[h & 12'hFFF] = b;
                2: begin rh[h & 12'hFFF] = b; rx[x & 12'hFFF] = a; end
                default: if (a != b) miss = 1'b1;
            endcase
            steps++;
            if (!hf) h = (h + 1) & 16'hFFFF;
            if (!xf) x = (x + 1) & 18'h3FFFF;
            if (miss) break;
        end
        hend = h; xend = x;
    endtask

    task automatic do_xfer(input string req, input int op, input int h0, input int x0, input int len,
                           input bit hf, input bit xf, input bit al, input bit poke);
        int hend, xend, steps, n, v, cmd;
        bit miss;
        int exp_r [2:8];
        cmd = 8'h80 | (al ? 8'h20 : 0) | op;
        wr(2, h0 & 8'hFF); wr(3, (h0 >> 8) & 8'hFF);
        wr(4, x0 & 8'hFF); wr(5, (x0 >> 8) & 8'hFF); wr(6, (x0 >> 16) & 3);
        wr(7, len & 8'hFF); wr(8, (len >> 8) & 8'hFF);
        wr(10, (hf ? 8'h80 : 0) | (xf ? 8'h40 : 0));
        ref_run(op, h0, x0, len, hf, xf, hend, xend, miss, steps);
        wr(1, cmd);
        n = 0;
        if (poke) begin
            wr(2, h0 ^ 8'h5A);  // R12 ignored while busy
            wr(1, 8'h81);       // R12 restart ignored
        end
        while (busy) begin n++; @(negedge clk); end
        if (!poke) chk(n == 2 * steps + 1, "R13", {req, " busy cycles"}, n, 2 * steps + 1);
        cmp_mem(req);
        rd(0, v);
        chk(v == (miss ? 8'h60 : 8'h40), miss ? "R6" : "R7", {req, " status"}, v, miss ? 8'h60 : 8'h40);
        rd(0, v);
        chk(v == 0, "R7", {req, " status after read"}, v, 0);
        rd(1, v);
        chk(v == cmd, "R12", {req, " command kept"}, v, cmd);
        if (al) begin
            exp_r[2] = h0 & 8'hFF; exp_r[3] = (h0 >> 8) & 8'hFF;
            exp_r[4] = x0 & 8'hFF; exp_r[5] = (x0 >> 8) & 8'hFF; exp_r[6] = (x0 >> 16) & 3;
        end else begin
            exp_r[2] = hend & 8'hFF; exp_r[3] = (hend >> 8) & 8'hFF;
            exp_r[4] = xend & 8'hFF; exp_r[5] = (xend >> 8) & 8'hFF; exp_r[6] = (xend >> 16) & 3;
        end
        exp_r[7] = len & 8'hFF; exp_r[8] = (len >> 8) & 8'hFF;
        for (int r = 2; r <= 8; r++) begin
            rd(r, v);
            chk(v == exp_r[r], "R11", $sformatf("%s reg %0d", req, r), v, exp_r[r]);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        int v, b;
        void'($urandom(32'd20250511));
        for (int i = 0; i < 4096; i++) begin
            rh[i] = 8'($urandom); rx[i] = 8'($urandom);
            hm[i] <= rh[i]; xm[i] <= rx[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        for (int r = 0; r <= 10; r++) begin
            rd(r, v);
            chk(v == 0, "R1", $sformatf("reg %0d after reset", r), v, 0);
        end

        // R2 commands that must not start
        wr(7, 5);
        wr(1, 8'h90);
        b = 0;
        repeat (4) begin @(negedge clk); b += int'(busy); end
        chk(b == 0, "R2", "busy after 0x90", b, 0);
        rd(1, v);
        chk(v == 8'h90, "R2", "stored 0x90", v, 8'h90);
        wr(1, 8'h03);
        repeat (4) begin @(negedge clk); b += int'(busy); end
        chk(b == 0, "R2", "busy after 0x03", b, 0);
        cmp_mem("R2");

        // directed modes
        do_xfer("R3", 0, 16'h0100, 18'h00200, 16, 0, 0, 0, 0);
        do_xfer("R6", 3, 16'h0100, 18'h00200, 16, 0, 0, 0, 0);   // equal, runs full
        hm[12'h105] <= ~rh[12'h105];
        rh[12'h105] = ~rh[12'h105];
        @(negedge clk);
        do_xfer("R6", 3, 16'h0100, 18'h00200, 16, 0, 0, 0, 0);   // stops at 6th byte
        do_xfer("R4", 1, 16'h0300, 18'h20400, 12, 0, 0, 0, 0);
        do_xfer("R5", 2, 16'h0500, 18'h10600, 9, 0, 0, 0, 0);
        do_xfer("R5", 2, 16'h0700, 18'h00700, 1, 0, 0, 0, 0);
        do_xfer("R9", 0, 16'hFFFE, 18'h3FFFC, 8, 0, 0, 0, 0);
        do_xfer("R10", 0, 16'h0900, 18'h00A00, 7, 1, 0, 0, 0);
        do_xfer("R10", 1, 16'h0B00, 18'h00C00, 7, 0, 1, 0, 0);
        do_xfer("R11", 2, 16'h0D00, 18'h30E00, 10, 0, 0, 1, 0);
        do_xfer("R12", 0, 16'h0F00, 18'h01000, 12, 0, 0, 0, 1);

        // random transfers
        for (int k = 0; k < 16; k++) begin
            do_xfer($sformatf("R3..random%0d", k), int'($urandom % 4), int'($urandom & 16'hFFFF),
                    int'($urandom & 18'h3FFFF), 1 + int'($urandom % 40),
                    ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 1, 0);
        end

        // R8 length 0 means 65536
        do_xfer("R8", 0, 16'h0000, 18'h3FFF0, 0, 0, 0, 0, 0);

        summary();
        $finish;
    end

endmodule